// File: doc/BRIEF.md
# Three-Lane Video Link Scrambler

This block sits on the transmit side of a three-lane serial video link, between the character source and the 10-bit line encoder. On every clock one 8-bit character arrives for each of the three data lanes. The block XORs each character with eight keystream bits taken from a 16-bit linear-feedback shift register that belongs to that lane, and passes the result on one cycle later. Each lane starts from its own fixed seed, so the three lanes never carry the same keystream.

Scrambling is switched on by the link rate: above the high-rate threshold it is always on, and below it only when a capability input reports that both ends of the link support it. While it is off, characters pass through untouched and every register holds its seed. A resynchronisation request, accepted only inside a control period, makes the block send a burst of eight unscrambled control characters on all three lanes at once, during which all three registers reload their seeds; the first character after the burst is scrambled with the seed itself.

Top module: `vlink_scrambler`

## Requirements
- R1: While `rst_n` is low, `char_out` is zero and `ucc_send` is zero; after reset every lane register holds its seed.
- R2: When scrambling is off (`high_rate` and `both_capable` both 0), `char_out` equals the `char_in` of the previous cycle, `ucc_send` is 0, and no burst is in progress.
- R3: Scrambling is on whenever `high_rate` is 1, and also when `high_rate` is 0 and `both_capable` is 1.
- R4: Each lane register s (bits 15..0) advances per character by eight steps of s <= {s[14:0], s[15]^s[4]^s[3]^s[2]} (polynomial x^16+x^5+x^4+x^3+1); output bit i of the character (bit 0 first) is input bit i XOR s[15] taken before step i. Lane n occupies bits 8n+7..8n of `char_in` and `char_out`.
- R5: The lane seeds are 16'hFFFF for lane 0, 16'hFFFE for lane 1 and 16'hFFFD for lane 2; the seed scrambles the first character after reset, after a burst, or after scrambling turns back on.
- R6: With scrambling on, `sync_req` = 1 while `period_kind` = 3 (control) and no burst was sent on the previous character starts a burst: that character and the next seven are output unchanged with `ucc_send` = 3'b111 on all lanes together, and all registers reload their seeds.
- R7: Outside a burst, characters of every period kind (0 video, 1 data island, 2 guard band, 3 control) are scrambled.
- R8: `sync_req` with `period_kind` other than 3 is ignored, and so is a request during a burst or on the character right after one; a burst never lasts more than eight characters.
- R9: Turning scrambling off mid-burst ends the burst; on re-enable, scrambling restarts from the seeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| char_in | input | 24 | Three 8-bit lane characters, lane 0 in the low byte |
| period_kind | input | 2 | 0 video, 1 data island, 2 guard band, 3 control |
| high_rate | input | 1 | Link runs above the high-rate threshold |
| both_capable | input | 1 | Both ends support scrambling at low rate |
| sync_req | input | 1 | Request for an unscrambled control burst |
| char_out | output | 24 | Scrambled (or passed) characters, one cycle after input |
| ucc_send | output | 3 | Per-lane flag: this character is an unscrambled control code |

## Verification
Characters are driven as all-zeros, which exposes the raw keystream of each lane and so tells a wrong seed or tap from a wrong XOR, as all-ones and counting patterns, and as random bytes over every period kind. Both enable paths are swept separately and together, with the block switched off for stretches to see that data passes and the seeds stay. Requests are placed outside control periods, inside a burst, on the character right after a burst and just before disabling, which separates a correct eight-character burst from one that is too long, restarted, or left to run while disabled.

// File: rtl/vlink_scr_pkg.sv
package vlink_scr_pkg;
    localparam int CHAR_W = 8;
    localparam int LFSR_W = 16;

    typedef logic [LFSR_W-1:0] lfsr_t;
    typedef logic [CHAR_W-1:0] char_t;

    typedef enum logic [1:0] {
        PK_VIDEO  = 2'd0,
        PK_ISLAND = 2'd1,
        PK_GUARD  = 2'd2,
        PK_CTRL   = 2'd3
    } period_e;

    // One shift of the x^16+x^5+x^4+x^3+1 register, output at bit 15.
    function automatic lfsr_t lfsr_step(lfsr_t s);
        return {s[LFSR_W-2:0], s[15] ^ s[4] ^ s[3] ^ s[2]};
    endfunction
endpackage

// File: rtl/vlink_scr_lane.sv
module vlink_scr_lane
    import vlink_scr_pkg::*;
(
    input  lfsr_t state_q,
    input  char_t data_in,
    output char_t data_out,
    output lfsr_t state_adv
);
    always_comb begin
        lfsr_t s;
        s = state_q;
        for (int i = 0; i < CHAR_W; i++) begin
            data_out[i] = data_in[i] ^ s[LFSR_W-1];
            s = lfsr_step(s);
        end
        state_adv = s;
    end
endmodule

// File: rtl/vlink_burst_ctrl.sv
module vlink_burst_ctrl #(
    parameter int BURST_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scr_on,
    input  logic start_req,
    output logic in_burst
);
    localparam int CNT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             busy;
    } bst_t;

    bst_t st_d, st_q;

    always_comb begin
        logic accept;
        st_d     = st_q;
        accept   = start_req && !st_q.busy && (st_q.cnt == '0);
        in_burst = scr_on && ((st_q.cnt != '0) || accept);
        if (!scr_on)
            st_d.cnt = '0;
        else if (st_q.cnt != '0)
            st_d.cnt = st_q.cnt - 1'b1;
        else if (accept)
            st_d.cnt = CNT_W'(BURST_LEN - 1);
        else
            st_d.cnt = '0;
        st_d.busy = in_burst;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/vlink_scrambler.sv
module vlink_scrambler
    import vlink_scr_pkg::*;
#(
    parameter int LANES     = 3,
    parameter int BURST_LEN = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES*CHAR_W-1:0] char_in,
    input  logic [1:0]              period_kind,
    input  logic                    high_rate,
    input  logic                    both_capable,
    input  logic                    sync_req,
    output logic [LANES*CHAR_W-1:0] char_out,
    output logic [LANES-1:0]        ucc_send
);
    localparam int DATA_W = LANES * CHAR_W;

    typedef struct packed {
        logic [LANES-1:0][LFSR_W-1:0] lfsr;
        logic [DATA_W-1:0]            data;
        logic [LANES-1:0]             ucc;
    } top_t;

    top_t st_d, st_q;

    logic [LANES-1:0][LFSR_W-1:0] seed_vec;
    logic [LANES-1:0][LFSR_W-1:0] adv_vec;
    logic [DATA_W-1:0]            scr_data;
    logic                         scr_on;
    logic                         in_burst;

    assign scr_on = high_rate || both_capable;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam lfsr_t SEED = lfsr_t'({LFSR_W{1'b1}} - g);
        assign seed_vec[g] = SEED;
        vlink_scr_lane i_lane (
            .state_q  (st_q.lfsr[g]),
            .data_in  (char_in[g*CHAR_W +: CHAR_W]),
            .data_out (scr_data[g*CHAR_W +: CHAR_W]),
            .state_adv(adv_vec[g])
        );
    end

    vlink_burst_ctrl #(.BURST_LEN(BURST_LEN)) i_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .scr_on   (scr_on),
        .start_req(sync_req && (period_e'(period_kind) == PK_CTRL)),
        .in_burst (in_burst)
    );

    always_comb begin
        st_d = st_q;
        if (!scr_on) begin
            st_d.data = char_in;
            st_d.lfsr = seed_vec;
            st_d.ucc  = '0;
        end else if (in_burst) begin
            st_d.data = char_in;
            st_d.lfsr = seed_vec;
            st_d.ucc  = '1;
        end else begin
            st_d.data = scr_data;
            st_d.lfsr = adv_vec;
            st_d.ucc  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.lfsr <= seed_vec;
            st_q.data <= '0;
            st_q.ucc  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign char_out = st_q.data;
    assign ucc_send = st_q.ucc;
endmodule

// File: rtl/vlink_scrambler_chk.sv
module vlink_scrambler_chk #(
    parameter int LANES     = 3,
    parameter int BURST_LEN = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [LANES*8-1:0]   char_in,
    input logic [1:0]           period_kind,
    input logic                 high_rate,
    input logic                 both_capable,
    input logic                 sync_req,
    input logic [LANES*8-1:0]   char_out,
    input logic [LANES-1:0]     ucc_send
);
    logic on;
    int   run_q;
    assign on = high_rate || both_capable;

    always_ff @(posedge clk) begin
        if (!rst_n)           run_q <= 0;
        else if (ucc_send[0]) run_q <= run_q + 1;
        else                  run_q <= 0;
    end

    always_comb begin
        if (!rst_n) AST_RESET_QUIET: assert (ucc_send == '0); // R1
    end

    AST_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !on |=> char_out == $past(char_in)); // R2
    AST_OFF_NO_UCC: assert property (@(posedge clk) disable iff (!rst_n)
        !on |=> ucc_send == '0); // R2
    AST_UCC_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
        ucc_send == '0 || ucc_send == '1); // R6
    AST_UCC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ucc_send[0] |-> char_out == $past(char_in)); // R6
    AST_REQ_START: assert property (@(posedge clk) disable iff (!rst_n)
        (on && sync_req && period_kind == 2'd3 && !ucc_send[0]) |=> ucc_send[0]); // R6
    AST_NO_LONG_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        ucc_send[0] |-> run_q < BURST_LEN); // R8
endmodule

bind vlink_scrambler vlink_scrambler_chk #(.LANES(LANES), .BURST_LEN(BURST_LEN)) i_chk (
    .clk(clk), .rst_n(rst_n), .char_in(char_in), .period_kind(period_kind),
    .high_rate(high_rate), .both_capable(both_capable), .sync_req(sync_req),
    .char_out(char_out), .ucc_send(ucc_send)
);

// File: tb/test_vlink_scrambler.sv
module test_vlink_scrambler;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] char_in = '0;
    logic [1:0]  period_kind = '0;
    logic        high_rate = 1'b0;
    logic        both_capable = 1'b0;
    logic        sync_req = 1'b0;
    logic [23:0] char_out;
    logic [2:0]  ucc_send;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [15:0] m_lfsr [3];
    int          m_cnt;
    bit          m_busy;

    always #5 clk = ~clk;

    vlink_scrambler i_vlink_scrambler (
        .clk(clk), .rst_n(rst_n), .char_in(char_in), .period_kind(period_kind),
        .high_rate(high_rate), .both_capable(both_capable), .sync_req(sync_req),
        .char_out(char_out), .ucc_send(ucc_send)
    );

    function automatic logic [15:0] seed_of(int lane);
        return 16'hFFFF - 16'(lane);
    endfunction

    task automatic check(string req, logic [23:0] act, logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int l = 0; l < 3; l++) m_lfsr[l] = seed_of(l);
        m_cnt = 0;
        m_busy = 0;
    endtask

    // Drive one character, predict, then check one cycle later.
    task automatic step(bit hr, bit cap, bit req, logic [1:0] kind, logic [23:0] d, string tag);
        logic [23:0] exp_d;
        logic [2:0]  exp_u;
        bit          on, start, burst;
        string       t;
        high_rate = hr; both_capable = cap; sync_req = req;
        period_kind = kind; char_in = d;
        on    = hr || cap;                      // R3
        start = req && kind == 2'd3 && !m_busy && m_cnt == 0;
        burst = on && (m_cnt != 0 || start);
        t = tag;
        if (!on) begin
            exp_d = d; exp_u = 3'b000;
            for (int l = 0; l < 3; l++) m_lfsr[l] = seed_of(l);
            m_cnt = 0;
            if (t == "") t = "R2";
        end else if (burst) begin
            exp_d = d; exp_u = 3'b111;
            for (int l = 0; l < 3; l++) m_lfsr[l] = seed_of(l);
            m_cnt = (m_cnt != 0) ? m_cnt - 1 : 7;
            if (t == "") t = "R6";
        end else begin
            exp_u = 3'b000;
            if (t == "") t = (m_lfsr[0] == seed_of(0)) ? "R5" : "R7";
            for (int l = 0; l < 3; l++) begin
                logic [15:0] s;
                s = m_lfsr[l];
                for (int i = 0; i < 8; i++) begin  // R4
                    exp_d[l*8+i] = d[l*8+i] ^ s[15];
                    s = {s[14:0], s[15] ^ s[4] ^ s[3] ^ s[2]};
                end
                m_lfsr[l] = s;
            end
            m_cnt = 0;
        end
        m_busy = burst;
        @(negedge clk);
        check({t, " data"}, char_out, exp_d);
        check({t, " ucc"}, {21'd0, ucc_send}, {21'd0, exp_u});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 data", char_out, 24'd0);
        check("R1 ucc", {21'd0, ucc_send}, 24'd0);
        rst_n = 1'b1;
        model_reset();

        // R5: zeros right after reset expose each lane's seed keystream
        step(1, 0, 0, 2'd0, 24'h000000, "R5");
        step(1, 0, 0, 2'd0, 24'h000000, "R4");
        // R2: disabled, every kind, random data, requests ignored
        for (int i = 0; i < 40; i++)
            step(0, 0, i[0], 2'(i), 24'($urandom), "R2");
        // R3 + R7: high rate path, all kinds and several patterns
        for (int i = 0; i < 64; i++) begin
            logic [23:0] d;
            case (i % 4)
                0: d = 24'h000000;
                1: d = 24'hFFFFFF;
                2: d = {8'(i), 8'(i + 1), 8'(i + 2)};
                default: d = 24'($urandom);
            endcase
            step(1, 0, 0, 2'(i / 4), d, "R7");
        end
        // R8: requests outside control periods do nothing
        for (int k = 0; k < 3; k++) step(1, 1, 1, 2'(k), 24'($urandom), "R8");
        // R6: burst, with repeated requests inside (R8)
        for (int i = 0; i < 8; i++) step(1, 0, 1, 2'd3, 24'($urandom), "R6");
        // request right after the burst is refused, then seed scrambles
        step(1, 0, 1, 2'd3, 24'h000000, "R8");
        step(1, 0, 0, 2'd3, 24'h000000, "R4");
        // R3: capability-only path with a burst
        for (int i = 0; i < 20; i++) step(0, 1, i == 5, 2'd3, 24'($urandom), "");
        for (int i = 0; i < 20; i++) step(0, 1, 0, 2'(i), 24'h000000, "R3");
        // R9: disable mid-burst, then re-enable
        for (int i = 0; i < 3; i++) step(1, 1, 1, 2'd3, 24'($urandom), "R6");
        step(0, 0, 0, 2'd3, 24'h123456, "R9");
        step(0, 1, 0, 2'd0, 24'h000000, "R9");
        step(0, 1, 0, 2'd0, 24'h000000, "R9");
        // long random soak across all inputs
        for (int i = 0; i < 400; i++) begin
            int r = $urandom % 16;
            step(r != 0, r[1], r[2] & r[3], 2'($urandom), 24'($urandom), "");
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule